// File: doc/BRIEF.md
# RTC Domain Clock Control Register

This block is a single 32-bit control and status register kept in the battery-backed real-time-clock domain. It turns the low-speed external oscillator on or off, picks crystal or external-clock input for it, sets its drive strength, selects which source feeds the RTC, and gates that selection with a clock-enable bit. A read-only bit reports whether the low-speed external clock is stable. Analog oscillator behaviour is modelled only by the `lse_stable` input.

Software reaches the register through a simple memory-mapped port with byte strobes and a ready handshake. Accesses that follow one another directly are held off for a fixed number of wait cycles. Only the RTC-domain reset, driven by either the `rtcd_rst_n` pin or the `sw_dom_rst` request, restores the register. The ordinary system reset affects the bus port only. The oscillator and source fields change only while the backup write enable is high. The source field can be written once, and a further change needs a domain reset first. A free-running divide-by-32 counter, also cleared by the domain reset, produces a one-cycle enable for the divided high-speed clock.

Top module: `rtc_clkctl`

## Requirements
- R1: After a domain reset (`rtcd_rst_n` low or `sw_dom_rst` high at a clock edge), the register reads 0x0000_0018. A pulse on the system reset `rst_n` alone leaves the register contents unchanged.
- R2: With `bkp_wr_en`=1, a write with strobe bit 0 set loads bit 0 (oscillator enable) and bit 2 (bypass: 1 external clock, 0 resonator). The outputs `osc_en` and `osc_bypass` follow from the next cycle.
- R3: Bit 1 reads the value of `lse_stable` sampled at the previous clock edge. Bus writes to bit 1 have no effect.
- R4: Bits 4:3 hold the drive strength (00 weak, 01 medium-low, 10 medium-high, 11 strong, reset 11) and drive `osc_drive`. They are written whenever strobe bit 0 is set, whatever the value of `bkp_wr_en`.
- R5: While `bkp_wr_en`=0, writes leave bits 0, 2, 9:8 and 15 unchanged.
- R6: Bits 9:8 select the source (00 none, 01 low-speed external, 10 low-speed internal, 11 high-speed external divided by 32). A write loads this field only while it holds 00. Once it is non-zero it changes only through a domain reset, which returns it to 00.
- R7: Bit 15 enables the RTC clock. `rtc_src_sel` equals bits 9:8 when bit 15 is 1 and 00 otherwise. `rtc_clk_on` is 1 only when bit 15 is 1 and bits 9:8 are non-zero.
- R8: Bits 7:5, 14:10 and 31:16 always read zero and ignore writes.
- R9: Strobe bit 0 covers bits 7:0 and strobe bit 1 covers bits 15:8. Strobe bits 3:2 have no effect. Only word address 0x20 (byte addresses 0x20 to 0x23) reaches the register: writes elsewhere are ignored, and reads elsewhere return zero.
- R10: `req_ready` is high when no hold-off is pending. After a completed access, the next access waits WAIT_CYC cycles (default 2) before it completes. An access that arrives after at least WAIT_CYC idle cycles completes with no wait.
- R11: `hse_div_tick` is a one-cycle pulse every 32 clocks. The first pulse comes 31 clocks after a domain reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and high-speed clock |
| rst_n | input | 1 | System reset, active low (bus port only) |
| rtcd_rst_n | input | 1 | RTC-domain reset, active low, asynchronous |
| sw_dom_rst | input | 1 | Software domain-reset request, synchronous |
| bkp_wr_en | input | 1 | Backup write enable for the protected fields |
| lse_stable | input | 1 | Low-speed external clock stable indication |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane strobes |
| req_ready | output | 1 | Access completes in this cycle when valid |
| rsp_rdata | output | 32 | Read data, valid while a read completes |
| osc_en | output | 1 | Oscillator enable |
| osc_bypass | output | 1 | Oscillator bypass select |
| osc_drive | output | 2 | Oscillator drive strength |
| rtc_src_sel | output | 2 | Gated RTC source code |
| rtc_clk_on | output | 1 | RTC clock running |
| hse_div_tick | output | 1 | Divided high-speed clock enable |

## Verification
A wrong field value shows on the matching output pin one cycle after the write. A read back exposes it in the same cycle that the read completes. A lock on the source field that fails to engage shows up as a changed `rtc_src_sel` on the first rewrite after a selection. A missing domain reset path shows as a non-0x18 read right after reset. A hold-off counter that is off by one changes the wait count seen on the very next back-to-back access. A divider error shifts the first tick away from the 31st clock.

// File: rtl/rtc_clkctl_pkg.sv
package rtc_clkctl_pkg;

  typedef struct packed {
    logic       clken;
    logic [1:0] src;
    logic [1:0] drive;
    logic       byp;
    logic       en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{clken: 1'b0, src: 2'b00, drive: 2'b11, byp: 1'b0, en: 1'b0};

  // bits that carry state or status; everything else reads zero
  localparam logic [31:0] USED_MASK = 32'h0000_831F;

  function automatic logic [31:0] pack_ctl(input ctl_t c, input logic rdy);
    logic [31:0] r;
    r       = '0;
    r[0]    = c.en;
    r[1]    = rdy;
    r[2]    = c.byp;
    r[4:3]  = c.drive;
    r[9:8]  = c.src;
    r[15]   = c.clken;
    return r;
  endfunction

  function automatic ctl_t next_ctl(input ctl_t c, input logic [31:0] wd,
                                    input logic [3:0] strb, input logic bkp);
    ctl_t n;
    n = c;
    if (strb[0]) begin
      n.drive = wd[4:3];
      if (bkp) begin
        n.en  = wd[0];
        n.byp = wd[2];
      end
    end
    if (strb[1] && bkp) begin
      n.clken = wd[15];
      if (c.src == 2'b00) n.src = wd[9:8];
    end
    return n;
  endfunction

  function automatic logic [1:0] gated_src(input ctl_t c);
    return c.clken ? c.src : 2'b00;
  endfunction

endpackage

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
  parameter int          AW         = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h20,
  parameter int          WAIT_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          acc_done
);
  localparam int WCW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

  logic [WCW-1:0] hold_q;
  logic           addr_hit;

  assign addr_hit  = (req_addr & ~AW'(3)) == AW'(REG_OFFSET);
  assign req_ready = (hold_q == '0);
  assign acc_done  = req_valid && req_ready;
  assign wr_fire   = acc_done && req_write && addr_hit;
  assign rd_fire   = acc_done && !req_write && addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold_q <= '0;
    else if (acc_done)      hold_q <= WCW'(WAIT_CYC);
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && (WAIT_CYC != 0)) |=> !req_ready);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && hold_q == WCW'(1)) |=> req_ready);

endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_clkctl_pkg::*;
(
  input  logic        clk,
  input  logic        rtcd_rst_n,
  input  logic        sw_dom_rst,
  input  logic        bkp_wr_en,
  input  logic        lse_stable,
  input  logic        wr_fire,
  input  logic [31:0] wdata,
  input  logic [3:0]  strb,
  output ctl_t        ctl_q,
  output logic        rdy_q
);
  logic src_locked;
  logic gated_wr;

  assign src_locked = (ctl_q.src != 2'b00);
  assign gated_wr   = wr_fire && bkp_wr_en;

  always_ff @(posedge clk or negedge rtcd_rst_n) begin
    if (!rtcd_rst_n) begin
      ctl_q <= CTL_RST;
      rdy_q <= 1'b0;
    end else if (sw_dom_rst) begin
      ctl_q <= CTL_RST;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= lse_stable;
      if (wr_fire) ctl_q <= next_ctl(ctl_q, wdata, strb, bkp_wr_en);
    end
  end

  p_src_lock_r6: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    (src_locked && !sw_dom_rst) |=> (ctl_q.src == $past(ctl_q.src)));

  p_bkp_gate_r5: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    (!gated_wr && !sw_dom_rst) |=> ($stable(ctl_q.en) && $stable(ctl_q.byp)
                                     && $stable(ctl_q.clken) && $stable(ctl_q.src)));

  p_ready_flag_r3: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    !sw_dom_rst |=> (rdy_q == $past(lse_stable)));

  p_dom_reset_r1: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    sw_dom_rst |=> (ctl_q == CTL_RST && !rdy_q));

endmodule

// File: rtl/rtc_hse_div.sv
module rtc_hse_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rtcd_rst_n,
  input  logic sw_dom_rst,
  output logic tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));
  assign tick = wrap;

  always_ff @(posedge clk or negedge rtcd_rst_n) begin
    if (!rtcd_rst_n)     cnt_q <= '0;
    else if (sw_dom_rst) cnt_q <= '0;
    else if (wrap)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  p_single_tick_r11: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    tick |=> !tick);

  p_clear_tick_r11: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    sw_dom_rst |=> !tick);

endmodule

// File: rtl/rtc_clkctl.sv
module rtc_clkctl
  import rtc_clkctl_pkg::*;
#(
  parameter int         AW         = 8,
  parameter logic [7:0] REG_OFFSET = 8'h20,
  parameter int         WAIT_CYC   = 2,
  parameter int         DIV        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtcd_rst_n,
  input  logic          sw_dom_rst,
  input  logic          bkp_wr_en,
  input  logic          lse_stable,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_strb,
  output logic          req_ready,
  output logic [31:0]   rsp_rdata,
  output logic          osc_en,
  output logic          osc_bypass,
  output logic [1:0]    osc_drive,
  output logic [1:0]    rtc_src_sel,
  output logic          rtc_clk_on,
  output logic          hse_div_tick
);
  ctl_t ctl_q;
  logic rdy_q;
  logic wr_fire, rd_fire, acc_done;

  rtc_bus_port #(.AW(AW), .REG_OFFSET(REG_OFFSET), .WAIT_CYC(WAIT_CYC)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .wr_fire(wr_fire),
    .rd_fire(rd_fire), .acc_done(acc_done)
  );

  rtc_ctl_regs u_regs (
    .clk(clk), .rtcd_rst_n(rtcd_rst_n), .sw_dom_rst(sw_dom_rst),
    .bkp_wr_en(bkp_wr_en), .lse_stable(lse_stable), .wr_fire(wr_fire),
    .wdata(req_wdata), .strb(req_strb), .ctl_q(ctl_q), .rdy_q(rdy_q)
  );

  rtc_hse_div #(.DIV(DIV)) u_div (
    .clk(clk), .rtcd_rst_n(rtcd_rst_n), .sw_dom_rst(sw_dom_rst), .tick(hse_div_tick)
  );

  assign rsp_rdata   = rd_fire ? pack_ctl(ctl_q, rdy_q) : 32'h0;
  assign osc_en      = ctl_q.en;
  assign osc_bypass  = ctl_q.byp;
  assign osc_drive   = ctl_q.drive;
  assign rtc_src_sel = gated_src(ctl_q);
  assign rtc_clk_on  = ctl_q.clken && (ctl_q.src != 2'b00);

  p_clk_on_r7: assert property (@(posedge clk) disable iff (!rtcd_rst_n)
    rtc_clk_on |-> (rtc_src_sel != 2'b00));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_rdata & ~USED_MASK) == 32'h0));

  p_foreign_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !rd_fire) |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/rtc_clkctl_test.sv
`timescale 1ns/1ps
module rtc_clkctl_test;
  logic        clk = 1'b0;
  logic        rst_n, rtcd_rst_n, sw_dom_rst, bkp_wr_en, lse_stable;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_strb;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        osc_en, osc_bypass, rtc_clk_on, hse_div_tick;
  logic [1:0]  osc_drive, rtc_src_sel;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rtc_clkctl uut (
    .clk(clk), .rst_n(rst_n), .rtcd_rst_n(rtcd_rst_n), .sw_dom_rst(sw_dom_rst),
    .bkp_wr_en(bkp_wr_en), .lse_stable(lse_stable), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_strb(req_strb), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .osc_en(osc_en), .osc_bypass(osc_bypass), .osc_drive(osc_drive),
    .rtc_src_sel(rtc_src_sel), .rtc_clk_on(rtc_clk_on), .hse_div_tick(hse_div_tick)
  );

  // {bkp, strb, wdata, expected readback}
  localparam logic [68:0] VEC [0:7] = '{
    {1'b1, 4'h1, 32'h0000_0005, 32'h0000_0005},   // R2 enable+bypass, R4 drive to 00
    {1'b0, 4'h1, 32'h0000_00FF, 32'h0000_001D},   // R5 gated bits kept, R4 drive, R3 R8
    {1'b0, 4'h2, 32'h0000_8100, 32'h0000_001D},   // R5 source/enable blocked
    {1'b1, 4'h2, 32'h0000_8100, 32'h0000_811D},   // R6 first selection, R7 enable
    {1'b1, 4'h2, 32'h0000_0300, 32'h0000_011D},   // R6 locked, R7 enable cleared
    {1'b1, 4'hF, 32'hFFFF_FFFF, 32'h0000_811D},   // R8 R9 full word
    {1'b1, 4'h1, 32'h0000_0008, 32'h0000_8108},   // R2 R4 low byte
    {1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0000_8108}    // R9 no strobes
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, output logic [31:0] rd, output int w);
    w = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; w++;
    end
    rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    logic [31:0] rd; int w;
    bus(1'b1, 8'h20, d, s, rd, w);
  endtask

  task automatic rd_reg(output logic [31:0] v);
    int w;
    bus(1'b0, 8'h20, 32'h0, 4'h0, v, w);
  endtask

  function automatic logic [5:0] outs_from(input logic [31:0] r);
    return {r[0], r[2], r[4:3], (r[15] ? r[9:8] : 2'b00)};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int w, gap;
    rst_n = 0; rtcd_rst_n = 0; sw_dom_rst = 0; bkp_wr_en = 0; lse_stable = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_strb = 0;
    idle(3);
    rst_n = 1; rtcd_rst_n = 1;
    idle(3);

    // R1 reset state
    rd_reg(v);
    check("R1 reset readback", v, 32'h18);
    check("R1 reset outputs", {26'h0, osc_en, osc_bypass, osc_drive, rtc_src_sel},
          {26'h0, 6'b00_11_00});
    check("R7 clock off after reset", {31'h0, rtc_clk_on}, 32'h0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      bkp_wr_en = VEC[i][68];
      wr(VEC[i][63:32], VEC[i][67:64]);
      bkp_wr_en = 1'b0;
      check($sformatf("R2/R4/R5/R6/R7 vector %0d outputs", i),
            {26'h0, osc_en, osc_bypass, osc_drive, rtc_src_sel},
            {26'h0, outs_from(VEC[i][31:0])});
      idle(3);
      rd_reg(v);
      check($sformatf("R3/R8/R9 vector %0d readback", i), v, VEC[i][31:0]);
      idle(3);
    end

    // R1 system reset only
    rst_n = 0; idle(2); rst_n = 1; idle(3);
    rd_reg(v);
    check("R1 system reset keeps contents", v, 32'h8108);

    // R3 ready flag follows stable input, writes to it ignored
    lse_stable = 1'b1; idle(3);
    rd_reg(v);
    check("R3 ready flag set", v, 32'h810A);
    idle(3);
    bkp_wr_en = 1'b1; wr(32'h0, 4'h1); bkp_wr_en = 1'b0;
    idle(3);
    rd_reg(v);
    check("R3 write to flag ignored", v, 32'h8102);
    lse_stable = 1'b0; idle(3);
    rd_reg(v);
    check("R3 ready flag cleared", v, 32'h8100);
    idle(3);

    // R9 other address and upper lanes
    bkp_wr_en = 1'b1;
    bus(1'b1, 8'h24, 32'hFFFF_FFFF, 4'hF, v, w);
    idle(3);
    bus(1'b1, 8'h22, 32'hFFFF_FFFF, 4'hC, v, w);
    bkp_wr_en = 1'b0;
    idle(3);
    rd_reg(v);
    check("R9 foreign address and upper lanes ignored", v, 32'h8100);
    idle(3);
    bus(1'b0, 8'h24, 32'h0, 4'h0, v, w);
    check("R9 foreign read is zero", v, 32'h0);
    idle(3);

    // R10 wait cycles
    bus(1'b0, 8'h20, 32'h0, 4'h0, v, w);
    check("R10 isolated access waits", w, 0);
    bus(1'b0, 8'h20, 32'h0, 4'h0, v, w);
    check("R10 back-to-back waits", w, 2);
    idle(3);

    // R11 divider, measured from a software domain reset (also R1)
    sw_dom_rst = 1'b1; @(negedge clk); sw_dom_rst = 1'b0;
    gap = 0;
    while (!hse_div_tick && gap < 100) begin @(negedge clk); gap++; end
    check("R11 first tick after domain reset", gap, 31);
    @(negedge clk); gap = 1;
    while (!hse_div_tick && gap < 100) begin @(negedge clk); gap++; end
    check("R11 tick period", gap, 32);
    rd_reg(v);
    check("R1 software domain reset value", v, 32'h18);
    idle(3);

    // R6 new selection after domain reset, R7 gating
    bkp_wr_en = 1'b1; wr(32'h8200, 4'h2); bkp_wr_en = 1'b0;
    check("R6 R7 new source selected", {28'h0, rtc_clk_on, 1'b0, rtc_src_sel}, 32'h0000_000A);
    idle(3);
    bkp_wr_en = 1'b1; wr(32'h0100, 4'h2); bkp_wr_en = 1'b0;
    check("R7 disable gates source", {28'h0, rtc_clk_on, 1'b0, rtc_src_sel}, 32'h0);
    idle(3);
    rd_reg(v);
    check("R6 source held while disabled", v, 32'h0218);
    idle(3);

    // R6 pin domain reset clears source
    rtcd_rst_n = 1'b0; idle(2); rtcd_rst_n = 1'b1; idle(2);
    rd_reg(v);
    check("R6 R1 pin domain reset clears source", v, 32'h18);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule